// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes incoming frames from a byte stream and stores each one in a memory buffer. The buffers are described by a ring of receive descriptors held in the same memory. The engine reads one descriptor ahead. If that descriptor belongs to the engine, the engine copies the next frame into the descriptor's buffer and stops at the buffer size. It then writes the frame length into the descriptor and writes the status word back, which clears the ownership flag and records any error. After that it moves to the next descriptor. When the descriptor just serviced is flagged as the last of the list, the next one is taken from the list base again.

Software builds the ring, points the engine at it through the list base input and pulses a receive request. The request stays set until the engine finds a descriptor it does not own. At that point the engine parks and clears the request. Frames that arrive while no owned descriptor is ready are discarded, and a missed-frame counter keeps a tally of them.

Top module: `rx_ring_dma`

## Requirements
- R1: A descriptor is four 32-bit words, and descriptors sit 16 bytes apart starting at `list_base`. Word 0 holds three flags: bit 31 means owned by the engine, bit 30 means end of list and bit 27 means frame error. Bits 31:16 of word 1 give the buffer size in bytes. Word 2 gives the byte address of the buffer, which is 32-byte aligned. The memory port is word-addressed, and read data arrives one cycle after a read request. A frame may start no sooner than 8 cycles after the previous frame's last byte, or after `rx_req_set`.
- R2: The stored bytes of a frame go into consecutive words starting at the buffer address. The first byte of each word sits in bits 7:0, and each later byte sits 8 bits higher. Byte lanes beyond the stored bytes in the final word are written as zero.
- R3: After a frame, word 1 is written back as the buffer size in bits 31:16 and the stored byte count in bits 15:0.
- R4: After a frame, word 0 is written back with bit 31 cleared. Bit 27 is set if `in_err` was high on any byte of the frame or the frame was truncated, and cleared otherwise. Every other bit, including end-of-list, is kept as read.
- R5: Bytes that exceed the buffer size are not written. The length reported is then the buffer size, and the frame counts as erroneous.
- R6: After the engine services a descriptor with end-of-list set, the next fetch is at `list_base`. Otherwise the next fetch is 16 bytes higher.
- R7: When a fetched descriptor has bit 31 clear, `rx_req` falls and the engine makes no memory access until `rx_req_set` is pulsed. It then fetches the same descriptor again.
- R8: A frame whose first byte arrives while no owned descriptor is ready is dropped whole, with no memory write, and `missed_cnt` rises by exactly one.
- R9: After reset, `rx_req` is low, `missed_cnt` is zero and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| list_base | input | AW+2 | Byte address of the first descriptor, 16-byte aligned |
| rx_req_set | input | 1 | Pulse that sets the receive request |
| rx_req | output | 1 | Receive request state |
| in_valid | input | 1 | A byte is present on the stream |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Final byte of the frame |
| in_err | input | 1 | Frame error marker, may be high on any byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| missed_cnt | output | CW | Count of dropped frames |

## Verification
Some properties are checked on every cycle: the status writeback always releases the descriptor that was just serviced, and the reported length never exceeds the buffer size. Other per-cycle checks are that a parked engine stays off the memory bus and that the missed counter moves by at most one. The bench scenarios are needed for the rest: byte lane packing, the zeroed tail lanes and truncation against the buffer boundary. The same holds for the wrap back to the list base after the flagged descriptor, and for resuming at the same descriptor after a halt. Each of these shows only in the memory contents that a sequence of frames leaves behind.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_F0, ST_F1, ST_F2, ST_F3, ST_READY, ST_RECV, ST_WB1, ST_WB0
  } rx_st_t;
  localparam int ACT_BIT = 31;
  localparam int EOL_BIT = 30;
  localparam int ERR_BIT = 27;
  localparam int DESC_WORDS = 4;
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr import rxr_pkg::*; #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base_w,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] ptr_w
);
  localparam logic [AW-1:0] STEP = AW'(DESC_WORDS);
  always_ff @(posedge clk) begin
    if (rst) ptr_w <= base_w;
    else if (adv) ptr_w <= wrap ? base_w : ptr_w + STEP;
  end
endmodule

// File: rtl/rxr_lane_pack.sv
module rxr_lane_pack #(
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   take,
  input  logic [$clog2(LANES)-1:0] lane,
  input  logic [7:0]             din,
  input  logic                   flush,
  output logic [8*LANES-1:0]     merged
);
  logic [8*LANES-1:0] hold;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[8*g +: 8] = (take && lane == g) ? din : hold[8*g +: 8];
  end
  always_ff @(posedge clk) begin
    if (rst) hold <= '0;
    else if (take) hold <= flush ? '0 : merged;
  end
endmodule

// File: rtl/rxr_miss_ctr.sv
module rxr_miss_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (inc && count != {CW{1'b1}}) count <= count + 1'b1;
  end
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma import rxr_pkg::*; #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW+1:0] list_base,
  input  logic          rx_req_set,
  output logic          rx_req,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          in_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic [CW-1:0] missed_cnt
);
  localparam int LW = 16;
  localparam int BW = AW + 2;

  rx_st_t        st;
  logic [31:0]   w0, wb0, merged;
  logic [LW-1:0] size_q, cnt;
  logic [AW-1:0] buf_w, desc_w;
  logic          err_q, mid;
  logic          sof, take, fits, store, flush, miss_inc, adv;

  assign sof      = in_valid && !mid;
  assign take     = in_valid && ((st == ST_READY && sof) || st == ST_RECV);
  assign fits     = cnt < size_q;
  assign store    = take && fits;
  assign flush    = store && (cnt[1:0] == 2'd3 || in_last || (cnt + 1'b1) == size_q);
  assign miss_inc = sof && st != ST_READY;
  assign adv      = st == ST_WB0;

  always_comb begin
    wb0 = w0;
    wb0[ACT_BIT] = 1'b0;
    wb0[ERR_BIT] = err_q;
  end

  rxr_ring_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .base_w(list_base[BW-1:2]),
    .adv(adv), .wrap(w0[EOL_BIT]), .ptr_w(desc_w));

  rxr_lane_pack #(.LANES(4)) u_pack (
    .clk(clk), .rst(rst), .take(store), .lane(cnt[1:0]),
    .din(in_data), .flush(flush), .merged(merged));

  rxr_miss_ctr #(.CW(CW)) u_miss (
    .clk(clk), .rst(rst), .inc(miss_inc), .count(missed_cnt));

  assign rx_req = rx_req_q;
  logic rx_req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;  rx_req_q <= 1'b0;  w0 <= '0;  size_q <= '0;
      cnt <= '0;  buf_w <= '0;  err_q <= 1'b0;  mid <= 1'b0;
      mem_req <= 1'b0;  mem_we <= 1'b0;  mem_addr <= '0;  mem_wdata <= '0;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      if (in_valid) mid <= !in_last;
      if (rx_req_set) rx_req_q <= 1'b1;
      case (st)
        ST_IDLE: if (rx_req_q) begin
          mem_req <= 1'b1;  mem_addr <= desc_w;  st <= ST_F0;
        end
        ST_F0: begin
          mem_req <= 1'b1;  mem_addr <= desc_w + AW'(1);  st <= ST_F1;
        end
        ST_F1: begin
          mem_req <= 1'b1;  mem_addr <= desc_w + AW'(2);
          w0 <= mem_rdata;  st <= ST_F2;
        end
        ST_F2: begin
          size_q <= mem_rdata[31:16];  st <= ST_F3;
        end
        ST_F3: begin
          buf_w <= mem_rdata[BW-1:2];
          cnt   <= '0;
          err_q <= 1'b0;
          if (w0[ACT_BIT]) st <= ST_READY;
          else begin
            st <= ST_IDLE;
            if (!rx_req_set) rx_req_q <= 1'b0;
          end
        end
        ST_READY, ST_RECV: if (take) begin
          cnt   <= cnt + {{(LW-1){1'b0}}, store};
          err_q <= err_q | in_err | !fits;
          if (flush) begin
            mem_req <= 1'b1;  mem_we <= 1'b1;
            mem_addr  <= buf_w + AW'(cnt[LW-1:2]);
            mem_wdata <= merged;
          end
          st <= in_last ? ST_WB1 : ST_RECV;
        end
        ST_WB1: begin
          mem_req <= 1'b1;  mem_we <= 1'b1;
          mem_addr <= desc_w + AW'(1);  mem_wdata <= {size_q, cnt};
          st <= ST_WB0;
        end
        ST_WB0: begin
          mem_req <= 1'b1;  mem_we <= 1'b1;
          mem_addr <= desc_w;  mem_wdata <= wb0;
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxr_chk.sv
module rxr_chk import rxr_pkg::*; #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_req,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [CW-1:0] missed_cnt,
  input rx_st_t        st,
  input logic [AW-1:0] desc_w
);
  a_r1_write_has_req: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);

  a_r4_release_owned: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == ST_WB0) |-> (mem_we && mem_addr == $past(desc_w) && !mem_wdata[ACT_BIT]));

  a_r5_len_within_size: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == ST_WB1) |-> (mem_we && mem_wdata[15:0] <= mem_wdata[31:16]));

  a_r7_parked_quiet: assert property (@(posedge clk) disable iff (rst)
    (!rx_req && st == ST_IDLE) |-> !mem_req);

  a_r8_miss_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (missed_cnt == $past(missed_cnt) || missed_cnt == $past(missed_cnt) + 1'b1));
endmodule

bind rx_ring_dma rxr_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .rx_req(rx_req), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .missed_cnt(missed_cnt),
  .st(st), .desc_w(desc_w));

// File: tb/rx_ring_dma_tb.sv
module rx_ring_dma_tb;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int DBASE = 'h40;   // descriptor word address (byte 0x100)
  localparam int BBASE = 'h100;  // buffer word address (byte 0x400)
  localparam logic [31:0] SENT = 32'hA5A5_5A5A;

  logic clk = 0, rst = 1;
  logic [AW+1:0] list_base = 18'h100;
  logic rx_req_set = 0, in_valid = 0, in_last = 0, in_err = 0;
  logic [7:0] in_data = 0;
  logic rx_req, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [CW-1:0] missed_cnt;

  logic [31:0] mem [0:1023];
  logic [7:0]  fb [0:63];
  int errors = 0, checks = 0, wr_cnt = 0, req_cnt = 0;
  int dsize [0:3];

  always #2 clk = ~clk;

  rx_ring_dma #(.AW(AW), .CW(CW)) u_dut (
    .clk(clk), .rst(rst), .list_base(list_base), .rx_req_set(rx_req_set),
    .rx_req(rx_req), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_err(in_err), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .missed_cnt(missed_cnt));

  always @(posedge clk) begin
    if (mem_req) begin
      req_cnt <= req_cnt + 1;
      if (mem_we) begin
        mem[mem_addr[9:0]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else mem_rdata <= mem[mem_addr[9:0]];
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [31:0] exp_word(input int j, input int stored);
    logic [31:0] w = '0;
    for (int b = 0; b < 4; b++)
      if (4*j + b < stored) w[8*b +: 8] = fb[4*j + b];
    return w;
  endfunction

  task automatic arm(input int di, input int size);
    @(negedge clk);
    mem[DBASE + 4*di]     = 32'h8000_0055 | (di == 3 ? 32'h4000_0000 : 32'h0);
    mem[DBASE + 4*di + 1] = size << 16;
    mem[DBASE + 4*di + 2] = (BBASE + 16*di) << 2;
    for (int j = 0; j < 16; j++) mem[BBASE + 16*di + j] = SENT;
    dsize[di] = size;
  endtask

  task automatic send(input int len, input int errpos);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      fb[i] = 8'($urandom);
      in_valid = 1; in_data = fb[i]; in_last = (i == len - 1); in_err = (i == errpos);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0; in_err = 0;
    repeat (14) @(negedge clk);
  endtask

  task automatic check_frame(input int di, input int len, input bit berr);
    int size = dsize[di];
    int stored = (len < size) ? len : size;
    bit e = berr || (len > size);
    logic [31:0] w0x = 32'h0000_0055 | (di == 3 ? 32'h4000_0000 : 32'h0) | (e ? 32'h0800_0000 : 32'h0);
    check(mem[DBASE + 4*di], w0x, "R4 status word");
    check(mem[DBASE + 4*di + 1], (size << 16) | stored, "R3/R5 length word");
    for (int j = 0; j < (stored + 3) / 4; j++)
      check(mem[BBASE + 16*di + j], exp_word(j, stored), "R2 buffer word");
    check(mem[BBASE + 16*di + (stored + 3) / 4], SENT, "R5 no write past data");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    int seed = $urandom(1234);
    int len, errpos, di, wr0, rq0;
    bit berr;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check(32'(rx_req), 0, "R9 request after reset");
    check(32'(missed_cnt), 0, "R9 counter after reset");
    check(32'(mem_req), 0, "R9 no access in reset");
    rst = 0;
    arm(0, 12); arm(1, 13); arm(2, 9); arm(3, 0);
    repeat (4) @(negedge clk);
    check(32'(mem_req) + 32'(req_cnt), 0, "R7 no fetch before request");
    rx_req_set = 1; @(negedge clk); rx_req_set = 0;
    repeat (10) @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      di = k % 4;
      berr = 0; errpos = -1;
      case (k)
        0: len = 12;
        1: len = 14;
        2: len = 1;
        3: len = 5;
        default: begin
          len = 1 + $urandom % 48;
          berr = ($urandom % 4 == 0);
          if (berr) errpos = $urandom % len;
        end
      endcase
      send(len, errpos);
      check_frame(di, len, berr);   // R6: ring order and wrap via di
      if (k < 8) arm(di, 4 + $urandom % 37);
    end
    check(32'(rx_req), 0, "R7 request cleared at unowned descriptor");
    wr0 = wr_cnt; rq0 = req_cnt;
    send(7, -1);
    check(32'(missed_cnt), 1, "R8 first dropped frame");
    check(32'(wr_cnt - wr0), 0, "R8 no writes for dropped frame");
    check(32'(req_cnt - rq0), 0, "R7 parked engine quiet");
    send(3, -1);
    check(32'(missed_cnt), 2, "R8 second dropped frame");
    arm(0, 20);
    rx_req_set = 1; @(negedge clk); rx_req_set = 0;
    repeat (10) @(negedge clk);
    check(32'(rx_req), 1, "R7 request set again");
    send(10, 4);
    check_frame(0, 10, 1);  // R7 resumes at the same descriptor
    finish_up();
  end
endmodule